// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Port

This block connects two voice channels to a shared serial PCM highway. Each channel has its own 6-bit slot number and enable. In its slot, the channel shifts a parallel transmit sample out onto the common serial output. It also collects the bits of its receive slot from the common serial input and returns them as a parallel word with a one-cycle valid pulse. A single mode input picks the word format, either 8-bit companded or 14-bit two's-complement linear. A second mode input picks the frame-sync style, short or long. Transmit and receive each have their own frame sync.

All logic runs on one system clock. The highway bit clock, the two frame syncs and the serial input are registered into this clock domain. Bit edges are found by comparing successive samples of the bit clock, so the system clock must be several times faster than the bit clock. The serial output is released to high impedance whenever no channel owns the current bit. An active-low strobe marks exactly the bits being driven, so an external backplane buffer can follow it. A power-down input releases the highway and stops reception.

Top module: `pcm_tsi_port`

## Requirements
- R1: After reset, and until the first frame sync is seen, the strobe stays high, the serial output is not driven and no receive valid pulse occurs, even with a channel enabled.
- R2: In companded mode (lin_mode = 0), slot k covers frame bits 8k to 8k+7. The channel sends tx_word[7:0] there, most significant bit first, one bit per bit clock, changing after the rising edge.
- R3: In linear mode (lin_mode = 1), slot k covers frame bits 16k to 16k+15. The channel sends tx_word[13:0], most significant bit first, followed by two bits driven low, and the strobe is low for all 16 bits.
- R4: With long_sync = 0, frame bit 0 begins at the bit-clock rising edge that follows the rising edge at which the frame sync was sampled high.
- R5: With long_sync = 1, frame bit 0 begins at the first bit-clock rising edge at which the frame sync is sampled high after being sampled low.
- R6: The strobe is low during exactly the bit periods in which the serial output is driven, and the output is high impedance in every other bit period.
- R7: A channel whose enable is low does not drive its slot and produces no receive valid pulse.
- R8: When both channels hold the same slot number, channel 0 drives that slot with its own word and channel 1 stays silent. Both channels still receive that slot.
- R9: Receive bits are sampled at the bit-clock falling edge, most significant bit first. In companded mode rx_word holds the 8 bits in [7:0] with [13:8] zero. In linear mode it holds the first 14 bits of the slot and the two padding bits are ignored.
- R10: Each enabled channel raises its rx_valid for exactly one system clock per frame. The pulse comes after the falling edge of the last bit of its receive slot and before the next rising edge, with rx_word valid in the same cycle.
- R11: While pwr_dn is high, the strobe is high, the serial output is not driven and no receive valid pulse occurs.
- R12: Slot number 63 is honoured at the end of the 6-bit range, covering companded frame bits 504 to 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Highway bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive data |
| lin_mode | input | 1 | 0 companded 8-bit, 1 linear 14-bit |
| long_sync | input | 1 | 0 short frame sync, 1 long frame sync |
| pwr_dn | input | 1 | Power-down: release highway, stop reception |
| chan_en | input | NCH | Per-channel enable |
| slot_sel | input | NCH x SLOT_W | Per-channel slot number |
| tx_word | input | NCH x 14 | Per-channel transmit sample |
| pcm_tx | output | 1 | Tri-state serial transmit data |
| tx_strobe_n | output | 1 | Low while pcm_tx is driven |
| rx_word | output | NCH x 14 | Per-channel received sample |
| rx_valid | output | NCH | Per-channel received-sample pulse |

## Verification
The bench sweeps pairs of slot positions in companded mode and checks every bit period against a frame computed from the slot arithmetic. A slot base scaled by the wrong width or an off-by-one frame start would move data by whole bits and show up at once. Both sync styles are run in both formats, because treating a long sync like a short one shifts the whole frame by one bit. Linear frames check the two low padding bits and that the padding is dropped on receive; a design that kept the padding would return a word shifted left by two. Further cases cover both channels on one slot, a disabled channel, power-down, slot 63, and the time and width of every receive pulse. A priority mistake would show up as channel 1 data, and a pulse stretched or fired in the wrong phase would be reported.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;

  localparam int CMP_BITS      = 8;
  localparam int LIN_BITS      = 14;
  localparam int CMP_SLOT_LOG2 = 3;
  localparam int LIN_SLOT_LOG2 = 4;

  typedef enum logic {
    FMT_COMPANDED = 1'b0,
    FMT_LINEAR    = 1'b1
  } word_fmt_e;

  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_style_e;

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic tx_fs,
  input  logic rx_fs,
  input  logic rxd,
  output logic rst_sync_n,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic tx_fs_q,
  output logic rx_fs_q,
  output logic rxd_q
);

  logic [1:0] rst_pipe;
  logic [1:0] bclk_q, bclk_d;
  logic       tx_fs_d, rx_fs_d, rxd_d;

  // reset asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    bclk_d  = {bclk_q[0], bclk};
    tx_fs_d = tx_fs;
    rx_fs_d = rx_fs;
    rxd_d   = rxd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bclk_q  <= 2'b00;
      tx_fs_q <= 1'b0;
      rx_fs_q <= 1'b0;
      rxd_q   <= 1'b0;
    end else begin
      bclk_q  <= bclk_d;
      tx_fs_q <= tx_fs_d;
      rx_fs_q <= rx_fs_d;
      rxd_q   <= rxd_d;
    end
  end

  assign bclk_rise = bclk_q[0] & ~bclk_q[1];
  assign bclk_fall = ~bclk_q[0] & bclk_q[1];

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_tsi_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             sync_in,
  input  sync_style_e      style,
  output logic [CNT_W-1:0] bit_idx,
  output logic             in_frame,
  output logic             step
);

  localparam logic [CNT_W-1:0] LAST_IDX = '1;

  logic             armed_q, armed_d;
  logic             prev_sync_q, prev_sync_d;
  logic             in_frame_d, step_d, restart;
  logic [CNT_W-1:0] idx_d;

  always_comb begin
    armed_d     = armed_q;
    prev_sync_d = prev_sync_q;
    in_frame_d  = in_frame;
    idx_d       = bit_idx;
    step_d      = bit_rise;
    restart     = 1'b0;
    if (bit_rise) begin
      prev_sync_d = sync_in;
      if (style == SYNC_LONG) begin
        restart = sync_in & ~prev_sync_q;
        armed_d = 1'b0;
      end else begin
        restart = armed_q;
        armed_d = sync_in;
      end
      if (restart) begin
        idx_d      = '0;
        in_frame_d = 1'b1;
      end else if (in_frame) begin
        if (bit_idx == LAST_IDX) in_frame_d = 1'b0;
        else                     idx_d      = bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      prev_sync_q <= 1'b0;
      in_frame    <= 1'b0;
      bit_idx     <= '0;
      step        <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      prev_sync_q <= prev_sync_d;
      in_frame    <= in_frame_d;
      bit_idx     <= idx_d;
      step        <= step_d;
    end
  end

  AST_FRAME_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> bit_idx == '0);  // R4
  AST_INDEX_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !$past(bit_rise)) |-> $stable(bit_idx));  // R2

endmodule

// File: rtl/pcm_chan.sv
module pcm_chan
  import pcm_tsi_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int CNT_W  = SLOT_W + LIN_SLOT_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  word_fmt_e           fmt,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                en,
  input  logic                pd,
  input  logic [CNT_W-1:0]    tx_idx,
  input  logic                tx_in_frame,
  input  logic                tx_step,
  input  logic [LIN_BITS-1:0] tx_word,
  input  logic [CNT_W-1:0]    rx_idx,
  input  logic                rx_in_frame,
  input  logic                rx_fall,
  input  logic                rx_bit,
  output logic                tx_hit,
  output logic                tx_bit,
  output logic [LIN_BITS-1:0] rx_word,
  output logic                rx_valid
);

  localparam int SR_W  = 1 << LIN_SLOT_LOG2;
  localparam int PAD_W = SR_W - LIN_BITS;

  logic                     linear;
  logic [CNT_W-1:0]         base, slot_len, tx_off, rx_off;
  logic                     rx_hit;
  logic [LIN_SLOT_LOG2-1:0] off4;
  logic [LIN_BITS-1:0]      hold_q, hold_d, word_src, shifted;
  logic [SR_W-1:0]          sr_q, sr_d;
  logic [LIN_BITS-1:0]      word_d;
  logic                     valid_d;

  // slot placement
  always_comb begin
    linear   = (fmt == FMT_LINEAR);
    base     = linear ? (CNT_W'(slot) << LIN_SLOT_LOG2) : (CNT_W'(slot) << CMP_SLOT_LOG2);
    slot_len = linear ? CNT_W'(1 << LIN_SLOT_LOG2) : CNT_W'(1 << CMP_SLOT_LOG2);
    tx_off   = tx_idx - base;
    rx_off   = rx_idx - base;
    tx_hit   = en & ~pd & tx_in_frame & (tx_idx >= base) & (tx_off < slot_len);
    rx_hit   = en & ~pd & rx_in_frame & (rx_idx >= base) & (rx_off < slot_len);
  end

  // transmit bit select; the word is captured on the first bit of the slot
  always_comb begin
    off4     = tx_off[LIN_SLOT_LOG2-1:0];
    word_src = (tx_off == '0) ? tx_word : hold_q;
    shifted  = word_src << off4;
    if (linear) tx_bit = (int'(off4) < LIN_BITS) ? shifted[LIN_BITS-1] : 1'b0;
    else        tx_bit = shifted[CMP_BITS-1];
    hold_d = hold_q;
    if (tx_step && tx_hit && tx_off == '0) hold_d = tx_word;
  end

  // receive shift and completion
  always_comb begin
    sr_d    = sr_q;
    word_d  = rx_word;
    valid_d = 1'b0;
    if (rx_fall && rx_hit) begin
      sr_d = {sr_q[SR_W-2:0], rx_bit};
      if (rx_off == slot_len - 1'b1) begin
        valid_d = 1'b1;
        if (linear) word_d = sr_d[SR_W-1:PAD_W];
        else        word_d = {{(LIN_BITS-CMP_BITS){1'b0}}, sr_d[CMP_BITS-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      sr_q     <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      sr_q     <= sr_d;
      rx_word  <= word_d;
      rx_valid <= valid_d;
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);  // R10
  AST_RX_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_fall));  // R9
  AST_RX_QUIET_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd) |-> !rx_valid);  // R11

endmodule

// File: rtl/pcm_tsi_port.sv
module pcm_tsi_port
  import pcm_tsi_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int SLOT_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bclk,
  input  logic                          tx_fsync,
  input  logic                          rx_fsync,
  input  logic                          rx_data,
  input  logic                          lin_mode,
  input  logic                          long_sync,
  input  logic                          pwr_dn,
  input  logic [NCH-1:0]                chan_en,
  input  logic [NCH-1:0][SLOT_W-1:0]    slot_sel,
  input  logic [NCH-1:0][LIN_BITS-1:0]  tx_word,
  output logic                          pcm_tx,
  output logic                          tx_strobe_n,
  output logic [NCH-1:0][LIN_BITS-1:0]  rx_word,
  output logic [NCH-1:0]                rx_valid
);

  localparam int CNT_W = SLOT_W + LIN_SLOT_LOG2;

  logic             rst_sync_n;
  logic             bclk_rise, bclk_fall, tx_fs_q, rx_fs_q, rxd_q;
  logic [CNT_W-1:0] tx_idx, rx_idx;
  logic             tx_in_frame, rx_in_frame, tx_step, rx_step_unused;
  word_fmt_e        fmt;
  sync_style_e      style;
  logic [NCH-1:0]   hit, bits;
  logic             taken, sel_bit;
  logic             oe_q, oe_d, dat_q, dat_d;

  assign fmt   = word_fmt_e'(lin_mode);
  assign style = sync_style_e'(long_sync);

  pcm_in_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .tx_fs      (tx_fsync),
    .rx_fs      (rx_fsync),
    .rxd        (rx_data),
    .rst_sync_n (rst_sync_n),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .tx_fs_q    (tx_fs_q),
    .rx_fs_q    (rx_fs_q),
    .rxd_q      (rxd_q)
  );

  pcm_frame_timer #(.CNT_W(CNT_W)) u_tx_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_rise (bclk_rise),
    .sync_in  (tx_fs_q),
    .style    (style),
    .bit_idx  (tx_idx),
    .in_frame (tx_in_frame),
    .step     (tx_step)
  );

  pcm_frame_timer #(.CNT_W(CNT_W)) u_rx_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_rise (bclk_rise),
    .sync_in  (rx_fs_q),
    .style    (style),
    .bit_idx  (rx_idx),
    .in_frame (rx_in_frame),
    .step     (rx_step_unused)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pcm_chan #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .fmt         (fmt),
      .slot        (slot_sel[c]),
      .en          (chan_en[c]),
      .pd          (pwr_dn),
      .tx_idx      (tx_idx),
      .tx_in_frame (tx_in_frame),
      .tx_step     (tx_step),
      .tx_word     (tx_word[c]),
      .rx_idx      (rx_idx),
      .rx_in_frame (rx_in_frame),
      .rx_fall     (bclk_fall),
      .rx_bit      (rxd_q),
      .tx_hit      (hit[c]),
      .tx_bit      (bits[c]),
      .rx_word     (rx_word[c]),
      .rx_valid    (rx_valid[c])
    );
  end

  // lowest channel number owns a contested slot
  always_comb begin
    taken   = 1'b0;
    sel_bit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i] && !taken) begin
        taken   = 1'b1;
        sel_bit = bits[i];
      end
    end
  end

  always_comb begin
    oe_d  = oe_q;
    dat_d = dat_q;
    if (pwr_dn) begin
      oe_d  = 1'b0;
      dat_d = 1'b0;
    end else if (tx_step) begin
      oe_d  = taken;
      dat_d = sel_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_q  <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      dat_q <= dat_d;
    end
  end

  assign pcm_tx      = oe_q ? dat_q : 1'bz;
  assign tx_strobe_n = ~oe_q;

  AST_PD_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwr_dn |=> tx_strobe_n);  // R11
  AST_STROBE_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(tx_strobe_n) |-> $past(tx_step));  // R6
  AST_STROBE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_strobe_n |-> $past(tx_in_frame));  // R1

endmodule

// File: tb/pcm_tsi_port_test.sv
module pcm_tsi_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NCH        = 2;
  localparam int SLOT_W     = 6;

  logic clk = 1'b0;
  logic rst_n, bclk, tx_fs, rx_fs, rxd, lin, lng, pd;
  logic [NCH-1:0]             chan_en;
  logic [NCH-1:0][SLOT_W-1:0] slot_sel;
  logic [NCH-1:0][13:0]       tx_word;
  wire                        pcm_tx;
  logic                       tx_strobe_n;
  logic [NCH-1:0][13:0]       rx_word;
  logic [NCH-1:0]             rx_valid;

  int   checks = 0;
  int   errors = 0;
  int   cur_b = 0;
  bit   phase_low = 1'b1;
  bit   done = 1'b0;
  int   pulse_cnt [NCH];
  int   pulse_b   [NCH];
  bit   pulse_low [NCH];
  logic [13:0] pulse_word [NCH];
  int   dbl_pulse = 0;
  logic [NCH-1:0] prev_valid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_tsi_port #(.NCH(NCH), .SLOT_W(SLOT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .tx_fsync(tx_fs), .rx_fsync(rx_fs),
    .rx_data(rxd), .lin_mode(lin), .long_sync(lng), .pwr_dn(pd),
    .chan_en(chan_en), .slot_sel(slot_sel), .tx_word(tx_word),
    .pcm_tx(pcm_tx), .tx_strobe_n(tx_strobe_n), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rx_valid[c]) begin
        pulse_cnt[c]++;
        pulse_b[c]    = cur_b;
        pulse_low[c]  = phase_low;
        pulse_word[c] = rx_word[c];
        if (prev_valid[c]) dbl_pulse++;
      end
    end
    prev_valid = rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (bit %0d)", req, act, exp, cur_b);
    end
  endtask

  function automatic logic rxpat(input int b, input int seed);
    return (((b * 7 + seed) ^ (b >> 2)) & 1) != 0;
  endfunction

  task automatic clear_pulses();
    for (int c = 0; c < NCH; c++) begin
      pulse_cnt[c] = 0;
      pulse_b[c] = -1;
      pulse_low[c] = 1'b0;
      pulse_word[c] = '0;
    end
    dbl_pulse = 0;
  endtask

  // one frame: configure, sync, clock nbits bit periods, check every bit and the rx pulses
  task automatic run_frame(input bit lin_i, input bit long_i, input bit pd_i,
                           input int s0, input int s1, input bit e0, input bit e1,
                           input logic [13:0] w0, input logic [13:0] w1,
                           input int seed, input int nbits, input string tag);
    int w;
    int st [NCH];
    bit en [NCH];
    logic [13:0] wd [NCH];
    chan_en = '0;
    lin = lin_i; lng = long_i; pd = pd_i;
    slot_sel[0] = SLOT_W'(s0); slot_sel[1] = SLOT_W'(s1);
    tx_word[0] = w0; tx_word[1] = w1;
    w = lin_i ? 16 : 8;
    st[0] = s0 * w; st[1] = s1 * w;
    en[0] = e0; en[1] = e1;
    wd[0] = w0; wd[1] = w1;
    // sync prelude (R4 short, R5 long)
    tx_fs = 1'b1; rx_fs = 1'b1;
    repeat (HALF) @(negedge clk);
    if (!long_i) begin
      bclk = 1'b1; rxd = 1'b0;
      repeat (HALF) @(negedge clk);
      bclk = 1'b0; tx_fs = 1'b0; rx_fs = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    clear_pulses();
    for (int b = 0; b < nbits; b++) begin
      bit exp_oe;
      logic exp_bit;
      exp_oe = 1'b0;
      exp_bit = 1'b0;
      bclk = 1'b1; rxd = rxpat(b, seed); cur_b = b; phase_low = 1'b0;
      if (b == 0) chan_en = {e1, e0};
      for (int c = 0; c < NCH; c++) begin
        if (!exp_oe && en[c] && !pd_i && b >= st[c] && b < st[c] + w) begin
          int p;
          p = b - st[c];
          exp_oe = 1'b1;
          if (lin_i) exp_bit = (p < 14) ? wd[c][13 - p] : 1'b0;
          else       exp_bit = wd[c][7 - p];
        end
      end
      repeat (HALF) @(negedge clk);
      // R6 strobe tracks driven bits; R2/R3 data; R7/R8/R11 ownership
      check(tx_strobe_n === !exp_oe, {tag, " R6 strobe"}, int'(tx_strobe_n), int'(!exp_oe));
      if (exp_oe)
        check(pcm_tx === exp_bit, {tag, lin_i ? " R3 data" : " R2 data"}, int'(pcm_tx), int'(exp_bit));
      bclk = 1'b0; phase_low = 1'b1;
      if (long_i && b == 7) begin tx_fs = 1'b0; rx_fs = 1'b0; end
      repeat (HALF) @(negedge clk);
    end
    chan_en = '0; pd = 1'b0;
    repeat (2) begin
      bclk = 1'b1; cur_b = nbits; phase_low = 1'b0;
      repeat (HALF) @(negedge clk);
      bclk = 1'b0; phase_low = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    check(dbl_pulse == 0, {tag, " R10 pulse width"}, dbl_pulse, 0);
    for (int c = 0; c < NCH; c++) begin
      if (en[c] && !pd_i) begin
        logic [13:0] exp_w;
        int nb;
        exp_w = '0;
        nb = lin_i ? 14 : 8;
        for (int p = 0; p < nb; p++) exp_w = {exp_w[12:0], rxpat(st[c] + p, seed)};
        check(pulse_cnt[c] == 1, {tag, " R10 pulse count"}, pulse_cnt[c], 1);
        check(pulse_b[c] == st[c] + w - 1 && pulse_low[c], {tag, " R10 pulse timing"},
              pulse_b[c], st[c] + w - 1);
        check(pulse_word[c] === exp_w, {tag, " R9 rx word"}, int'(pulse_word[c]), int'(exp_w));
      end else begin
        check(pulse_cnt[c] == 0, {tag, pd_i ? " R11 rx quiet" : " R7 rx quiet"}, pulse_cnt[c], 0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; bclk = 1'b0; tx_fs = 1'b0; rx_fs = 1'b0; rxd = 1'b0;
    lin = 1'b0; lng = 1'b0; pd = 1'b0;
    chan_en = '0; slot_sel = '0; tx_word = '0;
    clear_pulses();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(tx_strobe_n === 1'b1, "R1 reset strobe", int'(tx_strobe_n), 1);
    check(rx_valid === '0, "R1 reset rx_valid", int'(rx_valid), 0);
    // R1: clocking with a channel enabled but no sync yet
    chan_en = 2'b11;
    for (int i = 0; i < 12; i++) begin
      bclk = 1'b1; rxd = i[0];
      repeat (HALF) @(negedge clk);
      check(tx_strobe_n === 1'b1, "R1 no sync strobe", int'(tx_strobe_n), 1);
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    check(pulse_cnt[0] == 0 && pulse_cnt[1] == 0, "R1 no sync rx", pulse_cnt[0] + pulse_cnt[1], 0);

    // R2 R4: companded short sync, slot sweep
    for (int k = 0; k < 8; k++)
      run_frame(1'b0, 1'b0, 1'b0, k, 7 - k, 1'b1, 1'b1,
                14'(8'hA5 ^ (k * 29)), 14'(8'h3C + k * 17), k + 3, 72, "cmp short sweep");
    // R5: companded long sync
    run_frame(1'b0, 1'b1, 1'b0, 5, 2, 1'b1, 1'b1, 14'h0C9, 14'h036, 11, 56, "cmp long");
    // R3 R4: linear short sync
    run_frame(1'b1, 1'b0, 1'b0, 1, 0, 1'b1, 1'b1, 14'h2D6B, 14'h1E0F, 5, 48, "lin short");
    // R3 R5: linear long sync
    run_frame(1'b1, 1'b1, 1'b0, 2, 4, 1'b1, 1'b1, 14'h3FFF, 14'h2001, 9, 96, "lin long");
    // R8: shared slot, channel 0 wins
    run_frame(1'b0, 1'b0, 1'b0, 1, 1, 1'b1, 1'b1, 14'h055, 14'h0FF, 2, 32, "R8 shared slot");
    // R7: channel 1 disabled
    run_frame(1'b0, 1'b0, 1'b0, 0, 2, 1'b1, 1'b0, 14'h0F0, 14'h0AA, 4, 32, "R7 ch1 off");
    // R11: power-down
    run_frame(1'b0, 1'b1, 1'b1, 0, 1, 1'b1, 1'b1, 14'h0FF, 14'h0FF, 6, 24, "R11 power-down");
    // R12: top of slot range
    run_frame(1'b0, 1'b0, 1'b0, 63, 62, 1'b1, 1'b1, 14'h081, 14'h07E, 7, 512, "R12 slot 63");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule